// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single compare channel of a timer peripheral. It watches one of two free-running 16-bit time-base counters and compares the selected count with a primary compare value. In the dual-edge modes it also compares it with a secondary value. From these compare hits it drives one output pin and raises an interrupt flag. The counters live outside the block, and the channel never stops or reloads them.

A 3-bit mode input chooses the behaviour of the pin. The choices are: off, set high once, set low once, toggle on every hit, one pulse, or a pulse that repeats each time the counter passes the two compare values. Each hit changes the pin one clock after the cycle in which the equality is seen. The sticky interrupt flag follows two clocks after that pin change. Software clears the flag through a dedicated clear input. Any change of the mode input reloads the pin to the starting level of the new mode.

Top module: `oc_channel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the pin and the interrupt flag are both 0.
- R2: With the select input at 0 the compares use counter A. With it at 1 they use counter B, and counter A is then ignored.
- R3: Mode 3'b001 starts with the pin low and drives it high on a primary hit. The pin stays high on later hits, and those later hits raise no interrupt event.
- R4: Mode 3'b010 starts with the pin high and drives it low on a primary hit. The pin then stays low.
- R5: Mode 3'b011 starts with the pin low and inverts it on every primary hit. Each inversion is an interrupt event.
- R6: Mode 3'b100 raises the pin on a primary hit and lowers it on the next secondary hit. After that, hits are ignored and the pin stays low until the mode changes.
- R7: Mode 3'b101 behaves like 3'b100 but re-arms after each falling edge, so every later primary hit followed by a secondary hit makes another pulse.
- R8: A pin change caused by a hit becomes visible in the cycle after the hit. The flag rises two cycles after that. In the two pulse modes only the falling edge raises the flag.
- R9: A counter that holds the compare value for several cycles produces exactly one hit.
- R10: The flag stays set until the clear input is high for one cycle, and reads 0 on the next cycle. If a clear and a new event reach the flag in the same cycle, the flag stays set.
- R11: Mode 3'b000 (and the unused codes 3'b110 and 3'b111) holds the pin low, ignores hits, and drops interrupt events still in flight.
- R12: A change of the mode input reloads the pin on the next cycle: high for 3'b010, low for every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tmr_a_i | input | CNT_W | Time-base counter A |
| tmr_b_i | input | CNT_W | Time-base counter B |
| tmr_sel_i | input | 1 | 0 selects counter A, 1 selects counter B |
| mode_i | input | 3 | Channel behaviour code |
| cmp_pri_i | input | CNT_W | Primary compare value (set / toggle / leading edge) |
| cmp_sec_i | input | CNT_W | Secondary compare value (trailing edge) |
| flag_clr_i | input | 1 | One-cycle clear of the interrupt flag |
| oc_pin_o | output | 1 | Compare output pin |
| flag_o | output | 1 | Sticky interrupt flag |

## Verification
A counter value applied in cycle k shows its effect on the pin in cycle k+1 and on the flag in cycle k+3. A clear applied in cycle k shows in cycle k+1. Mode changes reload the pin in cycle k+1. Every driver step records the cycle index in which each consequence is due, and the expected values are queued against those cycles. The monitor samples the outputs on the falling edge and compares only the entries whose cycle has arrived. Entries are also placed at k+2 to prove the flag is not early, and checks are placed after flushes and disables to prove that events in flight never arrive.

// File: rtl/oc_pkg.sv
package oc_pkg;

   typedef enum logic [2:0] {
      OC_OFF       = 3'b000,
      OC_SET_HI    = 3'b001,
      OC_SET_LO    = 3'b010,
      OC_TOGGLE    = 3'b011,
      OC_PULSE_ONE = 3'b100,
      OC_PULSE_RPT = 3'b101
   } oc_mode_e;

   // Off code and the two unused codes all park the channel.
   function automatic logic oc_active(input logic [2:0] m);
      return (m != OC_OFF) && (m <= OC_PULSE_RPT);
   endfunction

endpackage

// File: rtl/oc_match.sv
module oc_match #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic             hit_o
);

   logic eq;
   logic eq_q;

   assign eq    = (cnt_i == cmp_i);
   assign hit_o = eq & ~eq_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) eq_q <= 1'b0;
      else         eq_q <= eq;
   end

   // R9: a frozen counter and compare value never produce a fresh hit
   a_r9_one_hit_per_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($stable(cnt_i) && $stable(cmp_i)) |-> !hit_o);

endmodule

// File: rtl/oc_wave.sv
module oc_wave
   import oc_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [2:0] mode_i,
   input  logic       hit_pri_i,
   input  logic       hit_sec_i,
   output logic       pin_o,
   output logic       evt_o
);

   logic [2:0] mode_q;
   logic       pin_q, pin_d;
   logic       done_q, done_d;
   logic       mode_chg;

   assign mode_chg = (mode_i != mode_q);

   always_comb begin
      pin_d  = pin_q;
      done_d = done_q;
      evt_o  = 1'b0;
      if (mode_chg || !oc_active(mode_i)) begin
         pin_d  = (mode_i == OC_SET_LO);
         done_d = 1'b0;
      end else begin
         unique case (mode_i)
            OC_SET_HI: if (hit_pri_i && !pin_q) begin
               pin_d = 1'b1;
               evt_o = 1'b1;
            end
            OC_SET_LO: if (hit_pri_i && pin_q) begin
               pin_d = 1'b0;
               evt_o = 1'b1;
            end
            OC_TOGGLE: if (hit_pri_i) begin
               pin_d = ~pin_q;
               evt_o = 1'b1;
            end
            default: begin
               if (!pin_q) begin
                  if (hit_pri_i && !done_q) pin_d = 1'b1;
               end else if (hit_sec_i) begin
                  pin_d  = 1'b0;
                  evt_o  = 1'b1;
                  done_d = (mode_i == OC_PULSE_ONE);
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mode_q <= OC_OFF;
         pin_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         mode_q <= mode_i;
         pin_q  <= pin_d;
         done_q <= done_d;
      end
   end

   assign pin_o = pin_q;

   // R5: a primary hit in a settled toggle mode always inverts the pin
   a_r5_toggle_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == OC_TOGGLE && mode_q == OC_TOGGLE && hit_pri_i) |=> (pin_q != $past(pin_q)));

   // R6: a finished single pulse keeps the pin low while the mode holds
   a_r6_one_shot_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == OC_PULSE_ONE && mode_q == OC_PULSE_ONE && done_q) |=> !pin_q);

endmodule

// File: rtl/oc_irq.sv
module oc_irq #(
   parameter int LAG = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic evt_i,
   input  logic flush_i,
   input  logic clr_i,
   output logic flag_o
);

   logic last;
   logic flag_q;

   if (LAG > 8) begin : g_bad_lag
      $error("oc_irq: LAG must not exceed 8");
   end

   if (LAG == 0) begin : g_direct
      assign last = evt_i & ~flush_i;
   end else begin : g_chain
      logic [LAG-1:0] pipe_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni || flush_i) begin
            pipe_q <= '0;
         end else begin
            pipe_q[0] <= evt_i;
            for (int i = 1; i < LAG; i++) pipe_q[i] <= pipe_q[i-1];
         end
      end
      assign last = pipe_q[LAG-1];
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= (flag_q & ~clr_i) | last;
   end

   assign flag_o = flag_q;

   // R10: without a clear the flag never drops
   a_r10_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !clr_i) |=> flag_q);

   // R8: the end of the delay chain always lands in the flag
   a_r8_chain_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      last |=> flag_q);

endmodule

// File: rtl/oc_channel.sv
module oc_channel
   import oc_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int IRQ_LAG = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] tmr_a_i,
   input  logic [CNT_W-1:0] tmr_b_i,
   input  logic             tmr_sel_i,
   input  logic [2:0]       mode_i,
   input  logic [CNT_W-1:0] cmp_pri_i,
   input  logic [CNT_W-1:0] cmp_sec_i,
   input  logic             flag_clr_i,
   output logic             oc_pin_o,
   output logic             flag_o
);

   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_width
      $error("oc_channel: CNT_W must lie in 2..64");
   end

   logic [CNT_W-1:0] tbase;
   logic             hit_pri, hit_sec, evt, flush;

   assign tbase = tmr_sel_i ? tmr_b_i : tmr_a_i;
   assign flush = !oc_active(mode_i);

   oc_match #(.CNT_W(CNT_W)) u_pri (
      .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(tbase), .cmp_i(cmp_pri_i), .hit_o(hit_pri)
   );

   oc_match #(.CNT_W(CNT_W)) u_sec (
      .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(tbase), .cmp_i(cmp_sec_i), .hit_o(hit_sec)
   );

   oc_wave u_wave (
      .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
      .hit_pri_i(hit_pri), .hit_sec_i(hit_sec), .pin_o(oc_pin_o), .evt_o(evt)
   );

   oc_irq #(.LAG(IRQ_LAG)) u_irq (
      .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt), .flush_i(flush),
      .clr_i(flag_clr_i), .flag_o(flag_o)
   );

   // R11: a parked channel has a low pin one cycle later
   a_r11_off_pin_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oc_active(mode_i) |=> !oc_pin_o);

   // R3: once high in a settled set-high mode, the pin stays high
   a_r3_high_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == OC_SET_HI && $stable(mode_i) && oc_pin_o) |=> oc_pin_o);

endmodule

// File: tb/tb_oc_channel.sv
module tb_oc_channel;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] tmr_a = '0, tmr_b = '0;
   logic        tmr_sel = 1'b0;
   logic [2:0]  mode = 3'b000;
   logic [15:0] cmp_pri = 16'd10, cmp_sec = 16'd20;
   logic        flag_clr = 1'b0;
   logic        oc_pin, flag;

   oc_channel dut (
      .clk_i(clk), .rst_ni(rst_n), .tmr_a_i(tmr_a), .tmr_b_i(tmr_b),
      .tmr_sel_i(tmr_sel), .mode_i(mode), .cmp_pri_i(cmp_pri), .cmp_sec_i(cmp_sec),
      .flag_clr_i(flag_clr), .oc_pin_o(oc_pin), .flag_o(flag)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int    at;
      bit    is_flag;
      bit    val;
      string req;
   } exp_t;

   exp_t sb[$];
   int   cyc = 0;
   int   n_vec = 0;
   int   n_bad = 0;
   bit   reported = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input bit act, input bit exp_v, input string what);
      n_vec++;
      if (act !== exp_v) begin
         n_bad++;
         $display("FAIL %s: %s actual=%0b expected=%0b at cycle %0d", req, what, act, exp_v, cyc);
      end
   endtask

   // monitor: pops every expectation whose cycle has come
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].at == cyc) begin
            if (sb[i].is_flag) check(sb[i].req, flag, sb[i].val, "flag");
            else               check(sb[i].req, oc_pin, sb[i].val, "pin");
            sb.delete(i);
         end
      end
   end

   task automatic exp_pin(input int d, input bit v, input string req);
      exp_t e;
      e.at = cyc + d; e.is_flag = 1'b0; e.val = v; e.req = req;
      sb.push_back(e);
   endtask

   task automatic exp_flag(input int d, input bit v, input string req);
      exp_t e;
      e.at = cyc + d; e.is_flag = 1'b1; e.val = v; e.req = req;
      sb.push_back(e);
   endtask

   task automatic step(input logic [15:0] a, input logic [15:0] b);
      @(negedge clk);
      tmr_a = a;
      tmr_b = b;
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", oc_pin, 1'b0, "pin in reset");
      check("R1", flag, 1'b0, "flag in reset");
      rst_n = 1'b1;
      exp_pin(1, 1'b0, "R1");
      exp_flag(1, 1'b0, "R1");

      // set-high mode
      step(0, 0);  mode = 3'b001; exp_pin(1, 1'b0, "R3");
      step(9, 0);
      step(10, 0); exp_pin(1, 1'b1, "R3"); exp_flag(2, 1'b0, "R8"); exp_flag(3, 1'b1, "R8");
      step(11, 0); step(12, 0); step(13, 0);
      step(14, 0); flag_clr = 1'b1; exp_flag(1, 1'b0, "R10");
      step(10, 0); flag_clr = 1'b0; exp_pin(1, 1'b1, "R3"); exp_flag(3, 1'b0, "R3");
      step(11, 0); step(12, 0); step(13, 0);

      // set-low mode
      step(0, 0);  mode = 3'b010; exp_pin(1, 1'b1, "R12");
      step(10, 0); exp_pin(1, 1'b0, "R4"); exp_flag(3, 1'b1, "R4");
      step(11, 0); step(12, 0); step(13, 0);
      step(14, 0); flag_clr = 1'b1; exp_flag(1, 1'b0, "R10");
      step(10, 0); flag_clr = 1'b0; exp_pin(1, 1'b0, "R4");
      step(11, 0);

      // toggle mode, held counter, timer select
      step(0, 0);  mode = 3'b011; exp_pin(1, 1'b0, "R12");
      step(10, 0); exp_pin(1, 1'b1, "R5"); exp_flag(3, 1'b1, "R5");
      step(10, 0); exp_pin(1, 1'b1, "R9");
      step(10, 0); exp_pin(1, 1'b1, "R9");
      step(10, 0); exp_pin(1, 1'b1, "R9");
      step(11, 0);
      step(10, 0); exp_pin(1, 1'b0, "R5");
      step(11, 3); tmr_sel = 1'b1;
      step(10, 4); exp_pin(1, 1'b0, "R2");
      step(11, 10); exp_pin(1, 1'b1, "R2");
      step(11, 11); step(11, 12); step(11, 11);
      step(11, 12); flag_clr = 1'b1;
      step(11, 11); flag_clr = 1'b0; exp_flag(0 + 1, 1'b0, "R10");

      // off mode forces low and ignores hits
      step(11, 12); mode = 3'b000; exp_pin(1, 1'b0, "R11");
      step(11, 10); exp_pin(1, 1'b0, "R11");
      // pending event dropped by disable
      step(11, 11); mode = 3'b011; exp_pin(1, 1'b0, "R12");
      step(11, 10); exp_pin(1, 1'b1, "R5");
      step(11, 11); mode = 3'b000; exp_pin(1, 1'b0, "R11");
      exp_flag(2, 1'b0, "R11"); exp_flag(3, 1'b0, "R11");
      step(11, 12); step(11, 13); step(11, 14);

      // single pulse
      step(0, 0);  tmr_sel = 1'b0; mode = 3'b100; exp_pin(1, 1'b0, "R12");
      step(10, 0); exp_pin(1, 1'b1, "R6"); exp_flag(3, 1'b0, "R8");
      step(15, 0); exp_pin(1, 1'b1, "R6");
      step(20, 0); exp_pin(1, 1'b0, "R6"); exp_flag(2, 1'b0, "R8"); exp_flag(3, 1'b1, "R8");
      step(0, 0);
      step(10, 0); exp_pin(1, 1'b0, "R6");
      step(20, 0); exp_pin(1, 1'b0, "R6");
      step(21, 0); flag_clr = 1'b1;
      step(22, 0); flag_clr = 1'b0; exp_flag(0 + 1, 1'b0, "R10");

      // repeating pulse, clear colliding with a new event
      step(0, 0);  mode = 3'b101; exp_pin(1, 1'b0, "R12");
      step(10, 0); exp_pin(1, 1'b1, "R7");
      step(20, 0); exp_pin(1, 1'b0, "R7");
      step(0, 0);  exp_flag(1, 1'b0, "R8");
      step(10, 0); exp_pin(1, 1'b1, "R7"); flag_clr = 1'b1; exp_flag(1, 1'b1, "R10");
      step(20, 0); flag_clr = 1'b0; exp_pin(1, 1'b0, "R7"); exp_flag(1, 1'b1, "R10");
      exp_flag(3, 1'b1, "R7");
      step(21, 0); step(22, 0); step(23, 0); step(24, 0); step(25, 0);

      if (sb.size() != 0) begin
         n_bad++;
         $display("FAIL R8: actual=%0d pending expected=0 pending", sb.size());
      end
      report();
      $finish;
   end

endmodule